// File: doc/BRIEF.md
# Byte FIFO with Fractional Fill Trigger

This block is a synchronous byte queue meant to sit between a processor-side bus and a serial shifter, on either the transmit or the receive side. It stores up to sixteen bytes. It raises a level interrupt when the number of stored bytes reaches a programmable fraction of the depth. A receive buffer signals when enough bytes have arrived. A transmit buffer signals when it has drained far enough to be refilled.

When the queue enable is low, the block works as a one-byte holding register. It reports full after a single byte and uses a trigger of one entry. This gives the classic double-buffered behaviour: one byte in the holding register and one in the shifter. Pushes into a full queue and pops from an empty one are dropped, and each kind of misuse sets its own sticky flag. Only reset clears these flags.

A parameter selects the direction of the interrupt comparison. Every output is registered. The storage is written so that it can map onto a block RAM with a registered read port.

Top module: `byte_fifo_trig`

## Requirements
- R1: After reset the block shows level 0, empty 1, full 0, overflow 0, underflow 0. The interrupt reads 0 in the receive variant (TX_MODE=0) and 1 in the transmit variant (TX_MODE=1).
- R2: Bytes leave in the order they were accepted. The byte for an accepted pop appears on pop_data in the clock cycle after the edge that took the pop.
- R3: At each clock edge the level rises by one for an accepted push and falls by one for an accepted pop. It is unchanged when both are accepted together. With the queue enabled, full is 1 exactly when the level is 16, and empty is 1 exactly when the level is 0.
- R4: A push while full is 1 is dropped: the level and the stored bytes are unchanged. It sets overflow, which stays 1 until reset.
- R5: A pop while empty is 1 is dropped: the level is unchanged. It sets underflow, which stays 1 until reset.
- R6: With the queue enabled, trig_sel picks the threshold as follows: 0 gives 2 entries, 1 gives 4, 2 gives 8, 3 gives 12, and 4 through 7 give 14.
- R7: In the receive variant, irq is 1 when the level is at or above the threshold. irq follows a level change in the same cycle as level does. It follows a change of trig_sel or fifo_en one edge later.
- R8: In the transmit variant, irq is 1 when the level is at or below the threshold, with the same timing as R7.
- R9: With fifo_en at 0, the capacity is one byte: full is 1 when the level is 1, and the threshold is 1 entry whatever trig_sel holds.
- R10: A push and a pop in the same cycle while full is 1 accepts only the pop: the level falls by one and overflow is set. The same while empty is 1 accepts only the push: the level becomes 1 and underflow is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: sixteen-entry queue; 0: one-byte holding register |
| trig_sel | input | 3 | Threshold fraction select (see R6) |
| push | input | 1 | Write request |
| push_data | input | 8 | Byte to write |
| full | output | 1 | No room for another byte |
| pop | input | 1 | Read request |
| pop_data | output | 8 | Byte read, valid the cycle after an accepted pop |
| empty | output | 1 | No byte stored |
| level | output | 5 | Number of stored bytes |
| irq | output | 1 | Fill-level interrupt |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: a pop was dropped |

## Verification
The bench builds two copies with DEPTH=16 and the 8-bit width: a receive copy with TX_MODE=0 and a transmit copy with TX_MODE=1. Both copies get the same stimulus, so each cycle checks both comparison directions against the same fill level. Sixteen entries is few enough that the bench can walk the queue to full and back to empty, through all five thresholds and the out-of-range selects. It also reaches the dropped push and pop and the simultaneous push and pop at both extremes. The same copies are then switched into the one-byte mode.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    FRAC_EIGHTH   = 3'd0,
    FRAC_QUARTER  = 3'd1,
    FRAC_HALF     = 3'd2,
    FRAC_3QUARTER = 3'd3,
    FRAC_7EIGHTH  = 3'd4
  } frac_sel_e;

  // Entries for a threshold fraction; codes above 4 use the 7/8 point.
  function automatic int unsigned frac_entries(input logic [2:0] sel,
                                               input int unsigned depth);
    case (sel)
      FRAC_EIGHTH:   frac_entries = depth / 8;
      FRAC_QUARTER:  frac_entries = depth / 4;
      FRAC_HALF:     frac_entries = depth / 2;
      FRAC_3QUARTER: frac_entries = (depth * 3) / 4;
      default:       frac_entries = (depth * 7) / 8;
    endcase
  endfunction

endpackage

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] level_next,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          underflow
);

  localparam logic [LW-1:0] CAP_QUEUE = LW'(DEPTH);
  localparam logic [LW-1:0] CAP_HOLD  = LW'(1);

  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cap;
  logic          push_ok, pop_ok;

  assign cap     = fifo_en ? CAP_QUEUE : CAP_HOLD;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  assign wr_en   = push_ok;
  assign wr_addr = wp_q;
  assign rd_en   = pop_ok;
  assign rd_addr = rp_q;

  always_comb begin
    level_next = level + {{(LW-1){1'b0}}, push_ok} - {{(LW-1){1'b0}}, pop_ok};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q      <= '0;
      rp_q      <= '0;
      level     <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      level <= level_next;
      full  <= (level_next >= cap);
      empty <= (level_next == '0);
      if (push && full) overflow  <= 1'b1;
      if (pop && empty) underflow <= 1'b1;
    end
  end

  p_both_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !full && !empty) |=> $stable(level));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    level <= CAP_QUEUE);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> ($stable(level) && $stable(wp_q)));

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> ($stable(level) && $stable(rp_q)));

  p_udf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  p_hold_full_r9: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && push && empty) |=> full);

  p_full_both_r10: assert property (@(posedge clk) disable iff (rst)
    (push && pop && full) |=> (level == $past(level) - 1'b1));

  p_empty_both_r10: assert property (@(posedge clk) disable iff (rst)
    (push && pop && empty) |=> (level == LW'(1) && !empty));

endmodule

// File: rtl/fifo_trig.sv
module fifo_trig
  import fifo_trig_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter bit          TX_MODE = 1'b0,
  localparam int unsigned LW     = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [2:0]    trig_sel,
  input  logic [LW-1:0] level_next,
  input  logic [LW-1:0] level,
  output logic          irq
);

  logic [LW-1:0] thr;
  logic          hit;

  assign thr = fifo_en ? LW'(frac_entries(trig_sel, DEPTH)) : LW'(1);

  generate
    if (TX_MODE) begin : g_drain
      assign hit = (level_next <= thr);
    end else begin : g_fill
      assign hit = (level_next >= thr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= TX_MODE;
    else     irq <= hit;
  end

  generate
    if (TX_MODE) begin : g_chk_tx
      p_irq_tx_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> irq);
      p_irq_tx_full_r8: assert property (@(posedge clk) disable iff (rst)
        (level == LW'(DEPTH)) |-> !irq);
    end else begin : g_chk_rx
      p_irq_rx_empty_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (level != '0));
      p_irq_rx_full_r7: assert property (@(posedge clk) disable iff (rst)
        (level == LW'(DEPTH)) |-> irq);
    end
  endgenerate

endmodule

// File: rtl/byte_fifo_trig.sv
module byte_fifo_trig
  import fifo_trig_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned DW      = BYTE_W,
  parameter bit          TX_MODE = 1'b0,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned LW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [2:0]    trig_sel,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          empty,
  output logic [LW-1:0] level,
  output logic          irq,
  output logic          overflow,
  output logic          underflow
);

  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [LW-1:0] level_next;

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .push       (push),
    .pop        (pop),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .level_next (level_next),
    .level      (level),
    .full       (full),
    .empty      (empty),
    .overflow   (overflow),
    .underflow  (underflow)
  );

  fifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (push_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (pop_data)
  );

  fifo_trig #(.DEPTH(DEPTH), .TX_MODE(TX_MODE)) u_trig (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .trig_sel   (trig_sel),
    .level_next (level_next),
    .level      (level),
    .irq        (irq)
  );

  p_pop_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !(pop && !empty) |=> $stable(pop_data));

endmodule

// File: tb/sim_byte_fifo_trig.sv
module sim_byte_fifo_trig;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b1;
  logic [2:0] trig_sel = 3'd2;
  logic       push = 1'b0;
  logic       pop = 1'b0;
  logic [7:0] din = 8'h00;

  logic [7:0] dout0, dout1;
  logic       full0, empty0, irq0, ovf0, udf0;
  logic       full1, empty1, irq1, ovf1, udf1;
  logic [4:0] level0, level1;

  always #5 clk = ~clk;

  byte_fifo_trig #(.DEPTH(16), .TX_MODE(1'b0)) u0 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .push(push), .push_data(din), .full(full0), .pop(pop), .pop_data(dout0),
    .empty(empty0), .level(level0), .irq(irq0), .overflow(ovf0), .underflow(udf0));

  byte_fifo_trig #(.DEPTH(16), .TX_MODE(1'b1)) u1 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .push(push), .push_data(din), .full(full1), .pop(pop), .pop_data(dout1),
    .empty(empty1), .level(level1), .irq(irq1), .overflow(ovf1), .underflow(udf1));

  int   vecs = 0;
  int   errs = 0;
  int   m_level = 0;
  bit   m_ovf = 0;
  bit   m_udf = 0;
  bit   pend_pop = 0;
  logic [7:0] pend_data = 8'h00;
  logic [7:0] exp_q [$];
  bit   done = 0;

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input bit en, input logic [2:0] s);
    if (!en) return 1;
    case (s)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      default: return 14;
    endcase
  endfunction

  task automatic check_state(input string tag);
    int cap;
    int thr;
    cap = fifo_en ? 16 : 1;
    thr = thr_of(fifo_en, trig_sel);
    check({tag, " level"}, int'(level0), m_level);
    check({tag, " full"}, int'(full0), int'(m_level >= cap));
    check({tag, " empty"}, int'(empty0), int'(m_level == 0));
    check({tag, " irq rx"}, int'(irq0), int'(m_level >= thr));
    check({tag, " irq tx"}, int'(irq1), int'(m_level <= thr));
    check({tag, " overflow"}, int'(ovf0), int'(m_ovf));
    check({tag, " underflow"}, int'(udf0), int'(m_udf));
  endtask

  // Driver: decides acceptance from the requirements and feeds the scoreboard.
  task automatic step(input bit p, input bit q, input logic [7:0] d, input string tag);
    int cap;
    bit ok_push, ok_pop;
    @(negedge clk);
    push = p; pop = q; din = d;
    cap = fifo_en ? 16 : 1;
    ok_push = p && (m_level < cap);
    ok_pop  = q && (m_level > 0);
    if (p && m_level >= cap) m_ovf = 1;
    if (q && m_level == 0) m_udf = 1;
    if (ok_pop) pend_data = exp_q.pop_front();
    if (ok_push) exp_q.push_back(d);
    pend_pop = ok_pop;
    m_level = m_level + int'(ok_push) - int'(ok_pop);
    @(posedge clk);
    #1;
    push = 0; pop = 0;
    check_state(tag);
  endtask

  task automatic set_cfg(input bit en, input logic [2:0] s);
    @(negedge clk);
    fifo_en = en; trig_sel = s;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; push = 0; pop = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_level = 0; m_ovf = 0; m_udf = 0; pend_pop = 0;
    exp_q.delete();
  endtask

  // Monitor: compares popped bytes with the scoreboard queue.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (pend_pop) begin
        check("R2 pop order rx", int'(dout0), int'(pend_data));
        check("R2 pop order tx", int'(dout1), int'(pend_data));
        pend_pop = 0;
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1 level", int'(level0), 0);
    check("R1 empty", int'(empty0), 1);
    check("R1 full", int'(full0), 0);
    check("R1 overflow", int'(ovf0), 0);
    check("R1 underflow", int'(udf0), 0);
    check("R1 irq rx", int'(irq0), 0);
    check("R1 irq tx", int'(irq1), 1);

    // Fill to the top with a half-depth threshold.
    set_cfg(1'b1, 3'd2);
    for (int i = 0; i < 16; i++) step(1, 0, 8'(i * 7 + 3), "R3 R7 R8 fill");
    step(1, 0, 8'hEE, "R4 push on full");
    // Drain a few, then hold level with paired transfers.
    for (int i = 0; i < 3; i++) step(0, 1, 8'h00, "R2 R3 drain");
    for (int i = 0; i < 4; i++) step(1, 1, 8'(8'hA0 + i), "R3 paired");

    // Threshold sweep at level 13, then at level 4.
    for (int s = 0; s < 8; s++) begin
      set_cfg(1'b1, 3'(s));
      step(0, 0, 8'h00, "R6 R7 R8 sweep13");
    end
    for (int i = 0; i < 9; i++) step(0, 1, 8'h00, "R2 drain");
    for (int s = 0; s < 8; s++) begin
      set_cfg(1'b1, 3'(s));
      step(0, 0, 8'h00, "R6 R7 R8 sweep4");
    end

    // Refill to full, then push and pop together on full.
    set_cfg(1'b1, 3'd4);
    for (int i = 0; i < 12; i++) step(1, 0, 8'(8'h50 + i), "R3 refill");
    step(1, 1, 8'h77, "R10 both on full");
    for (int i = 0; i < 15; i++) step(0, 1, 8'h00, "R2 R3 empty out");
    step(0, 1, 8'h00, "R5 pop on empty");
    step(1, 1, 8'h3C, "R10 both on empty");
    step(0, 1, 8'h00, "R2 after both");

    // One-byte holding mode.
    do_reset();
    set_cfg(1'b0, 3'd3);
    step(0, 0, 8'h00, "R9 hold idle");
    step(1, 0, 8'h91, "R9 hold push");
    step(1, 0, 8'h92, "R9 R4 hold push on full");
    step(1, 1, 8'h93, "R9 R10 hold both on full");
    step(1, 0, 8'h94, "R9 hold push");
    for (int s = 0; s < 8; s++) begin
      set_cfg(1'b0, 3'(s));
      step(0, 0, 8'h00, "R9 hold sweep");
    end
    step(0, 1, 8'h00, "R9 R2 hold pop");
    step(0, 1, 8'h00, "R9 R5 hold pop empty");
    step(1, 1, 8'h95, "R9 R10 hold both on empty");
    step(0, 1, 8'h00, "R9 R2 hold pop");

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule